// File: doc/BRIEF.md
# Burst SRAM Control Front-End

This block is the synchronous control path of a flow-through burst static RAM, with a small storage array attached so that it can be exercised on its own. A cycle starts when one of two address strobes is sampled low. The "cpu" strobe always begins a read and is gated by the main select. The "controller" strobe is not gated by the main select, needs the cpu strobe to be idle, and samples the write enables on its own edge. Three chip selects qualify each start. If any select is wrong, the block drops to a deselected, undriven state.

After an address is loaded, an advance input steps through the four-word burst. The order depends on a strap input: XOR on the low two address bits, or a wrapping increment. A global write and a byte-write path with one enable per lane choose which 9-bit lanes of the 18-bit word are stored. Reads are flow-through: the word at the registered address appears on `rdata_o` in the same cycle. `rdata_oe_o` tells the pad ring when to drive the bus. A sleep input makes the block ignore strobes and keeps the bus undriven, and the array keeps its contents.

Top module: `burst_sram_ctl`

## Requirements
- R1: With `cpu_strobe_ni` low and `sel_main_ni` low (other selects valid), the external address is loaded and a read begins. This holds whatever the write enables and `ctl_strobe_ni` are.
- R2: With `sel_main_ni` high, a low `cpu_strobe_ni` is blocked. If `ctl_strobe_ni` is high, the running burst continues as if no strobe were present.
- R3: `ctl_strobe_ni` starts a cycle only while the cpu strobe is not active. On that same edge the write enables decide whether the cycle is a write, and a write stores `wdata_i` at the newly loaded address.
- R4: `step_ni` is ignored on a cpu-strobe load edge. On later edges with no strobe, `step_ni` low advances the burst and `step_ni` high holds the current address.
- R5: With `seq_xor_i`=1, the low two address bits follow base^1, base^2, base^3. With `seq_xor_i`=0, they follow base+1, base+2, base+3 modulo 4.
- R6: Address bits above bit 1 never change during a burst, including when the low bits wrap.
- R7: `wr_all_ni` low writes both lanes. Otherwise, `wr_bytes_ni` low writes each lane whose `lane_en_ni` bit is low (bit 0 selects data bits 8:0, bit 1 selects bits 17:9). With no lane selected, the cycle is a read.
- R8: The lane enables are ignored on a cpu-strobe load edge. On later edges, a selected lane writes the current burst address, and the burst advances in the same edge if `step_ni` is low.
- R9: Each of the following deselects the block and leaves the bus undriven: `sel_main_ni` high while the controller strobe is active; `sel_hi_i` low at a strobe; `sel_lo_ni` high at a strobe.
- R10: `rdata_oe_o` is high only in a read cycle with `out_en_ni` low, and it follows `out_en_ni` without a clock edge. It is low in any cycle in which a write was sampled, whatever `out_en_ni` is.
- R11: Read data for the registered address appears on `rdata_o` in the same cycle as the load, with no output register.
- R12: While `sleep_i` is high, strobes and writes are ignored, the burst address is held, `rdata_oe_o` is low and the array keeps its contents.
- R13: While `rst_ni` is low, the block is deselected and `rdata_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 20 | External word address |
| cpu_strobe_ni | input | 1 | Cpu-side address strobe, active low |
| ctl_strobe_ni | input | 1 | Controller-side address strobe, active low |
| sel_main_ni | input | 1 | Main chip select, active low |
| sel_hi_i | input | 1 | Chip select, active high |
| sel_lo_ni | input | 1 | Chip select, active low |
| step_ni | input | 1 | Burst advance, active low |
| wr_all_ni | input | 1 | Global write, active low |
| wr_bytes_ni | input | 1 | Byte-write path enable, active low |
| lane_en_ni | input | 2 | Per-lane write enables, active low |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| seq_xor_i | input | 1 | Burst order strap: 1 XOR, 0 increment |
| sleep_i | input | 1 | Sleep: ignore strobes, release bus |
| wdata_i | input | 18 | Write data |
| rdata_o | output | 18 | Flow-through read data |
| rdata_oe_o | output | 1 | Bus drive enable for read data |

## Verification
Assertions check four things on every edge. A deselect or a committed write leaves the bus undriven in the next cycle. A cpu-strobe load always becomes a read. Sleep and a held advance both freeze the burst address. The upper address bits stay fixed outside a load. Some behaviour needs known memory contents, and only the directed scenarios can show it. These cover the XOR and increment orderings, partial lane writes that merge with old data, lane enables being ignored on a load edge, and a sleep-time write that leaves no trace.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  localparam int unsigned BURST_W = 2;
endpackage

// File: rtl/bsram_wr_dec.sv
module bsram_wr_dec #(
  parameter int unsigned LANES = 2
) (
  input  logic             wr_all_ni,
  input  logic             wr_bytes_ni,
  input  logic [LANES-1:0] lane_en_ni,
  output logic [LANES-1:0] mask_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mask_o[l] = !wr_all_ni || (!wr_bytes_ni && !lane_en_ni[l]);
  end
endmodule

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  input  logic              seq_xor_i,
  output logic [ADDR_W-1:0] addr_o
);
  import bsram_pkg::*;

  logic [ADDR_W-1:BURST_W] upper_q;
  logic [BURST_W-1:0]      base_q;
  logic [BURST_W-1:0]      cnt_q;
  logic [BURST_W-1:0]      low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      upper_q <= load_addr_i[ADDR_W-1:BURST_W];
      base_q  <= load_addr_i[BURST_W-1:0];
      cnt_q   <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // interleaved order xors the offset, linear order adds it (wraps in BURST_W bits)
  assign low    = seq_xor_i ? (base_q ^ cnt_q) : (base_q + cnt_q);
  assign addr_o = {upper_q, low};

  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(addr_o[ADDR_W-1:BURST_W])) else $error("upper bits moved"); // R6
  AST_HOLD_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i && $stable(seq_xor_i)) |=> $stable(addr_o)) else $error("address moved while held"); // R4
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic [LANES-1:0]  we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[l]) lane_mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = lane_mem[raddr_i];
  end
endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned DATA_W = LANES * LANE_W,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cpu_strobe_ni,
  input  logic              ctl_strobe_ni,
  input  logic              sel_main_ni,
  input  logic              sel_hi_i,
  input  logic              sel_lo_ni,
  input  logic              step_ni,
  input  logic              wr_all_ni,
  input  logic              wr_bytes_ni,
  input  logic [LANES-1:0]  lane_en_ni,
  input  logic              out_en_ni,
  input  logic              seq_xor_i,
  input  logic              sleep_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  import bsram_pkg::*;

  cyc_e              cyc_q, cyc_d;
  logic              cpu_hit, ctl_hit, strobe, chip_on;
  logic              load, desel, cont, wr_hit;
  logic [LANES-1:0]  mask, we;
  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  waddr;
  logic              unused_hi;

  // main select gates only the cpu strobe; a blocked cpu strobe lets the controller strobe through
  assign cpu_hit = !cpu_strobe_ni && !sel_main_ni;
  assign ctl_hit = !ctl_strobe_ni && !cpu_hit;
  assign strobe  = (cpu_hit || ctl_hit) && !sleep_i;
  assign chip_on = !sel_main_ni && sel_hi_i && !sel_lo_ni;
  assign load    = strobe && chip_on;
  assign desel   = strobe && !chip_on;
  assign cont    = !sleep_i && !cpu_hit && !ctl_hit && (cyc_q != CYC_IDLE);

  bsram_wr_dec #(.LANES(LANES)) u_wr_dec (
    .wr_all_ni  (wr_all_ni),
    .wr_bytes_ni(wr_bytes_ni),
    .lane_en_ni (lane_en_ni),
    .mask_o     (mask)
  );

  assign wr_hit = |mask;

  always_comb begin
    cyc_d = cyc_q;
    if (load)       cyc_d = (ctl_hit && wr_hit) ? CYC_WRITE : CYC_READ;
    else if (desel) cyc_d = CYC_IDLE;
    else if (cont)  cyc_d = wr_hit ? CYC_WRITE : CYC_READ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= CYC_IDLE;
    else         cyc_q <= cyc_d;
  end

  // lane enables count only on controller loads and on continuation edges
  assign we    = ((load && ctl_hit) || cont) ? mask : '0;
  assign waddr = load ? addr_i[IDX_W-1:0] : cur_addr[IDX_W-1:0];

  bsram_burst_ctr #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_addr_i(addr_i),
    .step_i     (cont && !step_ni),
    .seq_xor_i  (seq_xor_i),
    .addr_o     (cur_addr)
  );

  bsram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata_i),
    .raddr_i(cur_addr[IDX_W-1:0]),
    .rdata_o(rdata_o)
  );

  assign unused_hi  = ^cur_addr[ADDR_W-1:IDX_W];
  assign rdata_oe_o = (cyc_q == CYC_READ) && !out_en_ni && !sleep_i;

  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desel |=> !rdata_oe_o) else $error("bus driven after deselect"); // R9
  AST_WRITE_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|we) |=> !rdata_oe_o) else $error("bus driven after write"); // R10
  AST_CPU_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && cpu_hit) |=> (cyc_q == CYC_READ)) else $error("cpu load not a read"); // R1
  AST_SLEEP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && $stable(seq_xor_i)) |=> $stable(cur_addr)) else $error("address moved in sleep"); // R12
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> !rdata_oe_o) else $error("bus driven in reset"); // R13
endmodule

// File: tb/burst_sram_ctl_bench.sv
module burst_sram_ctl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [19:0] addr_i;
  logic        cpu_strobe_ni, ctl_strobe_ni, sel_main_ni, sel_hi_i, sel_lo_ni;
  logic        step_ni, wr_all_ni, wr_bytes_ni, out_en_ni, seq_xor_i, sleep_i;
  logic [1:0]  lane_en_ni;
  logic [17:0] wdata_i;
  logic [17:0] rdata_o;
  logic        rdata_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  burst_sram_ctl u_burst_sram_ctl (
    .clk_i, .rst_ni, .addr_i, .cpu_strobe_ni, .ctl_strobe_ni, .sel_main_ni,
    .sel_hi_i, .sel_lo_ni, .step_ni, .wr_all_ni, .wr_bytes_ni, .lane_en_ni,
    .out_en_ni, .seq_xor_i, .sleep_i, .wdata_i, .rdata_o, .rdata_oe_o
  );

  function automatic logic [17:0] pat(input int idx);
    return 18'((idx * 2731) ^ 18'h15A5A);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    cpu_strobe_ni = 1'b1; ctl_strobe_ni = 1'b1;
    sel_main_ni = 1'b0; sel_hi_i = 1'b1; sel_lo_ni = 1'b0;
    step_ni = 1'b1; wr_all_ni = 1'b1; wr_bytes_ni = 1'b1; lane_en_ni = 2'b11;
    out_en_ni = 1'b0; sleep_i = 1'b0; wdata_i = '0;
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic cpu_load(input logic [19:0] a);
    cpu_strobe_ni = 1'b0; addr_i = a;
    tick();
    cpu_strobe_ni = 1'b1;
  endtask

  task automatic t_reset();
    chk("R13 no drive in reset", rdata_oe_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    tick();
    chk("R13 idle after reset", rdata_oe_o, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 16; i++) begin
      ctl_strobe_ni = 1'b0; wr_all_ni = 1'b0;
      addr_i = 20'h3C010 + 20'(i); wdata_i = pat(16 + i);
      tick();
      if (i == 0) chk("R10 write forces hi-z", rdata_oe_o, 0);
      idle_in();
    end
    cpu_load(20'h3C01F);
    chk("R3 controller write stored", rdata_o, pat(31));
  endtask

  task automatic t_xor();
    seq_xor_i = 1'b1;
    step_ni = 1'b0;
    cpu_load(20'h3C012);
    chk("R11 flow-through data", rdata_o, pat(18));
    chk("R4 step ignored on load", rdata_oe_o, 1);
    tick(); chk("R5 xor 1st", rdata_o, pat(19));
    tick(); chk("R5 xor 2nd", rdata_o, pat(16));
    step_ni = 1'b1;
    tick(); chk("R4 hold", rdata_o, pat(16));
    step_ni = 1'b0;
    tick(); chk("R5 xor 3rd", rdata_o, pat(17));
    idle_in();
  endtask

  task automatic t_lin();
    seq_xor_i = 1'b0;
    cpu_load(20'h3C012);
    chk("R5 linear base", rdata_o, pat(18));
    step_ni = 1'b0;
    tick(); chk("R5 linear 1st", rdata_o, pat(19));
    tick(); chk("R6 wrap without carry", rdata_o, pat(16));
    tick(); chk("R5 linear 3rd", rdata_o, pat(17));
    tick(); chk("R5 linear back to base", rdata_o, pat(18));
    idle_in();
    seq_xor_i = 1'b1;
  endtask

  task automatic t_bytes();
    ctl_strobe_ni = 1'b0; addr_i = 20'h3C018;
    wr_bytes_ni = 1'b0; lane_en_ni = 2'b10; wdata_i = 18'h3FFFF;
    tick();
    lane_en_ni = 2'b01; wdata_i = 18'h00000;
    tick();
    lane_en_ni = 2'b11;
    tick();
    chk("R7 lane merge", rdata_o, 18'h001FF);
    chk("R7 no lane is read", rdata_oe_o, 1);
    wr_bytes_ni = 1'b1; lane_en_ni = 2'b00;
    tick();
    chk("R7 byte path off is read", rdata_oe_o, 1);
    idle_in();
    ctl_strobe_ni = 1'b0; wr_all_ni = 1'b0; wr_bytes_ni = 1'b1; lane_en_ni = 2'b11;
    wdata_i = 18'h2A5A5;
    tick(); idle_in(); tick();
    chk("R7 global write both lanes", rdata_o, 18'h2A5A5);
  endtask

  task automatic t_cont_write();
    wr_all_ni = 1'b0; wr_bytes_ni = 1'b0; lane_en_ni = 2'b00; wdata_i = '0;
    cpu_load(20'h3C01A);
    chk("R8 lanes ignored on cpu load", rdata_o, pat(26));
    chk("R1 cpu load reads", rdata_oe_o, 1);
    wr_all_ni = 1'b1; step_ni = 1'b0; wdata_i = 18'h2BEEF;
    tick();
    chk("R10 continuation write hi-z", rdata_oe_o, 0);
    idle_in();
    tick();
    chk("R8 advanced after write", rdata_o, pat(27));
    cpu_load(20'h3C01A);
    chk("R8 continuation write stored", rdata_o, 18'h2BEEF);
  endtask

  task automatic t_priority();
    cpu_strobe_ni = 1'b0; ctl_strobe_ni = 1'b0; wr_all_ni = 1'b0;
    addr_i = 20'h3C01C; wdata_i = '0;
    tick(); idle_in();
    chk("R1 cpu wins over controller", rdata_oe_o, 1);
    chk("R3 no write with cpu low", rdata_o, pat(28));
  endtask

  task automatic t_block();
    cpu_load(20'h3C010);
    sel_main_ni = 1'b1; cpu_strobe_ni = 1'b0; addr_i = 20'h3C017;
    tick(); idle_in();
    chk("R2 blocked strobe keeps data", rdata_o, pat(16));
    chk("R2 blocked strobe keeps drive", rdata_oe_o, 1);
  endtask

  task automatic t_desel();
    cpu_load(20'h3C011);
    chk("R9 pre read", rdata_oe_o, 1);
    ctl_strobe_ni = 1'b0; sel_main_ni = 1'b1;
    tick(); idle_in();
    chk("R9 main high with controller", rdata_oe_o, 0);
    tick();
    chk("R9 stays idle", rdata_oe_o, 0);
    cpu_load(20'h3C011);
    cpu_strobe_ni = 1'b0; sel_hi_i = 1'b0;
    tick(); idle_in();
    chk("R9 high select low", rdata_oe_o, 0);
    cpu_load(20'h3C011);
    cpu_strobe_ni = 1'b0; sel_lo_ni = 1'b1;
    tick(); idle_in();
    chk("R9 low select high", rdata_oe_o, 0);
  endtask

  task automatic t_oe();
    out_en_ni = 1'b1;
    cpu_load(20'h3C013);
    chk("R10 oe high no drive", rdata_oe_o, 0);
    out_en_ni = 1'b0; #1;
    chk("R10 oe acts without clock", rdata_oe_o, 1);
    chk("R11 data for address", rdata_o, pat(19));
  endtask

  task automatic t_sleep();
    cpu_load(20'h3C015);
    sleep_i = 1'b1; #1;
    chk("R12 sleep releases bus", rdata_oe_o, 0);
    ctl_strobe_ni = 1'b0; wr_all_ni = 1'b0; addr_i = 20'h3C015; wdata_i = '0;
    tick();
    chk("R12 strobe ignored in sleep", rdata_oe_o, 0);
    idle_in(); #1;
    chk("R12 read resumes after sleep", rdata_oe_o, 1);
    chk("R12 contents kept", rdata_o, pat(21));
  endtask

  initial begin
    idle_in(); addr_i = '0; seq_xor_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    t_fill();
    t_xor();
    t_lin();
    t_bytes();
    t_cont_write();
    t_priority();
    t_block();
    t_desel();
    t_oe();
    t_sleep();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule